// File: doc/BRIEF.md
# Core-First Supply Sequencer

This block is a clocked controller for a board with three switched supply rails: a primary rail, an I/O rail and a core rail. Each rail has an external power switch whose gate driver is enabled by one output of this block. The block receives a supply-good flag for each rail, already compared against its undervoltage threshold. From these flags, a few sequencing control pins and a 2-bit software shutdown code, it decides when each switch may conduct.

The primary rail produces a power-good output (`ready`) after a reset interval. The primary switch follows its own enable pin. The core and I/O rails are always sequenced so that the core switch closes first and opens last. Two sequencing styles exist. In the timed style, edges on one pin start and stop the sequence and fixed cycle counts separate the two rails. In the threshold style, edges on another pin start and stop it, and a comparator flag that reports the core rail above its reference releases the I/O switch. Each rail failure and each shutdown code has its own shutdown order. After a failure or override clears, the sequence restarts while a sequence request is still latched.

All delays are clock-cycle counts set by parameters. The asynchronous sequencing pins and the comparator pass through a synchronizer before edge detection.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: `ready` is 0 while `prim_ok` is 0. It becomes 1 once `prim_ok` has been 1 for RST_CYCLES consecutive clock edges. It falls in the same cycle that `prim_ok` falls.
- R2: `en_h` is 1 exactly when `gate_h_in` is 1, `prim_ok` is 1 and bit 1 of `shut_code` is 0. No clock edge is involved.
- R3: `en_l` is on only while `ready` and `core_ok` are 1. `en_m` additionally needs `io_ok`. A start request that arrives while a rail is bad starts nothing until the rails are good.
- R4: `en_m` is never 1 while `en_l` is 0.
- R5: In the timed style, a rising edge on `seq_time_in` sets `en_l` 3 edges later (2 synchronizer stages plus 1 state register). `en_m` follows UP_DELAY edges after `en_l`. The same spacing applies whenever a latched request restarts the sequence.
- R6: In the timed style, a falling edge on `seq_time_in` clears `en_m` 3 edges later. `en_l` clears DOWN_DELAY edges after `en_m`.
- R7: In the threshold style, a rising edge on `seq_volt_in` sets `en_l` 3 edges later. `en_m` stays 0 until the synchronized `core_above_ref` is 1, and then rises 3 edges after that input rises. A falling edge on `seq_volt_in` clears `en_m` 3 edges later and `en_l` DOWN_DELAY edges after that.
- R8: A rising edge on either sequencing pin selects that pin's style. A falling edge on the pin of the style not selected has no effect on the outputs.
- R9: When `prim_ok` falls, `ready`, `en_h`, `en_m` and `en_l` all fall in the same cycle.
- R10: When `io_ok` falls, `en_m` falls in the same cycle. `en_l` falls DOWN_DELAY+1 edges later.
- R11: When `core_ok` falls, `en_l` and `en_m` fall together in the same cycle.
- R12: `shut_code` bit 0 forces I/O-then-core shutdown: `en_m` drops at once and `en_l` drops DOWN_DELAY+1 edges later. Bit 1 forces `en_h` off at once. Code 2'b10 leaves `en_m` and `en_l` untouched. Code 2'b11 does both.
- R13: Returning `shut_code` to 2'b00 with the rails good and a request latched turns `en_h` on in the same cycle and `en_l` 1 edge later. `en_m` then follows in the selected style.
- R14: `stat[2]`, `stat[1]` and `stat[0]` always equal `en_h`, `en_m` and `en_l`, respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prim_ok | input | 1 | Primary rail above its undervoltage threshold |
| io_ok | input | 1 | I/O rail above its undervoltage threshold |
| core_ok | input | 1 | Core rail above its undervoltage threshold |
| gate_h_in | input | 1 | Enable request for the primary switch |
| seq_time_in | input | 1 | Timed-style sequence pin, edge sensitive, asynchronous |
| seq_volt_in | input | 1 | Threshold-style sequence pin, edge sensitive, asynchronous |
| core_above_ref | input | 1 | Core rail above its sequencing reference, asynchronous |
| shut_code | input | 2 | Software shutdown code (bit 0 core/I/O, bit 1 primary) |
| ready | output | 1 | Primary power-good |
| en_h | output | 1 | Primary switch enable |
| en_m | output | 1 | I/O switch enable |
| en_l | output | 1 | Core switch enable |
| stat | output | 3 | Command status {primary, I/O, core} |

## Verification
The bench concentrates on the asymmetric shutdown orders. An I/O rail failure, code 01 and code 03 must all hold the core switch on for the down-delay. A design that dropped both at once would release the core rail early. A design that waited on a core-rail failure would keep the I/O switch on with no core supply. The bench also holds a start request while the I/O rail is bad, which catches a controller that starts the core rail alone. It toggles the non-selected sequencing pin, which catches edge detection that ignores the style. It clears the override with the request latched, which catches a controller that forgets the request or turns on the I/O rail first.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE    = 2'd0,
      SQ_CORE_UP = 2'd1,
      SQ_BOTH_UP = 2'd2,
      SQ_IO_DOWN = 2'd3
   } seq_state_e;

   typedef enum logic {
      MODE_TIMED  = 1'b0,
      MODE_THRESH = 1'b1
   } seq_mode_e;

   typedef struct packed {
      logic drop_primary;
      logic drop_core_io;
   } shut_req_t;

   // bit 1 of the code acts on the primary switch, bit 0 on the core/I/O pair
   function automatic shut_req_t decode_shut(input logic [1:0] code);
      shut_req_t r;
      r.drop_primary = code[1];
      r.drop_core_io = code[0];
      return r;
   endfunction

endpackage

// File: rtl/pseq_sync.sv
module pseq_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   localparam int TOTAL = WIDTH * STAGES;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pseq_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("pseq_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [TOTAL-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[TOTAL-WIDTH-1:0], din};
      end
   end

   assign dout = chain_q[TOTAL-1 -: WIDTH];

endmodule

// File: rtl/pseq_ready_gen.sv
module pseq_ready_gen #(
   parameter int RST_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic prim_ok,
   output logic ready
);

   localparam int RW = $clog2(RST_CYCLES + 1);
   localparam logic [RW-1:0] CNT_DONE = RW'(RST_CYCLES);

   generate
      if (RST_CYCLES < 1) begin : g_bad_rst
         $error("pseq_ready_gen: RST_CYCLES must be at least 1");
      end
   endgenerate

   logic [RW-1:0] good_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         good_cnt_q <= '0;
      end else if (!prim_ok) begin
         good_cnt_q <= '0;
      end else if (good_cnt_q != CNT_DONE) begin
         good_cnt_q <= good_cnt_q + 1'b1;
      end
   end

   // prim_ok gates the count so a failure removes power-good without a clock edge
   assign ready = prim_ok && (good_cnt_q == CNT_DONE);

endmodule

// File: rtl/pseq_req_latch.sv
module pseq_req_latch
   import pseq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      time_s,
   input  logic      volt_s,
   output logic      req_nxt,
   output seq_mode_e mode_nxt
);

   logic      time_d, volt_d;
   logic      req_q;
   seq_mode_e mode_q;
   logic      time_rise, time_fall, volt_rise, volt_fall;
   logic      stop_edge;

   assign time_rise = time_s & ~time_d;
   assign time_fall = ~time_s & time_d;
   assign volt_rise = volt_s & ~volt_d;
   assign volt_fall = ~volt_s & volt_d;

   // only the pin of the style in force may withdraw the request
   assign stop_edge = (mode_q == MODE_TIMED) ? time_fall : volt_fall;

   always_comb begin
      mode_nxt = mode_q;
      if (time_rise) begin
         mode_nxt = MODE_TIMED;
      end else if (volt_rise) begin
         mode_nxt = MODE_THRESH;
      end
   end

   always_comb begin
      req_nxt = req_q;
      if (time_rise || volt_rise) begin
         req_nxt = 1'b1;
      end else if (stop_edge) begin
         req_nxt = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         time_d <= 1'b0;
         volt_d <= 1'b0;
         req_q  <= 1'b0;
         mode_q <= MODE_TIMED;
      end else begin
         time_d <= time_s;
         volt_d <= volt_s;
         req_q  <= req_nxt;
         mode_q <= mode_nxt;
      end
   end

endmodule

// File: rtl/pseq_core_io_seq.sv
module pseq_core_io_seq
   import pseq_pkg::*;
#(
   parameter int UP_DELAY   = 200,
   parameter int DOWN_DELAY = 200
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req,
   input  seq_mode_e mode,
   input  logic      above_ref,
   input  logic      ready,
   input  logic      io_ok,
   input  logic      core_ok,
   input  logic      hold_off,
   output logic      l_cmd,
   output logic      m_cmd
);

   localparam int MAXD = (UP_DELAY > DOWN_DELAY) ? UP_DELAY : DOWN_DELAY;
   localparam int CW   = $clog2(MAXD + 1);
   localparam logic [CW-1:0] UP_LAST = CW'(UP_DELAY - 1);
   localparam logic [CW-1:0] DN_LAST = CW'(DOWN_DELAY - 1);

   generate
      if (UP_DELAY < 1) begin : g_bad_up
         $error("pseq_core_io_seq: UP_DELAY must be at least 1");
      end
      if (DOWN_DELAY < 1) begin : g_bad_dn
         $error("pseq_core_io_seq: DOWN_DELAY must be at least 1");
      end
   endgenerate

   seq_state_e st_q, st_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic start_ok, stop_now, io_release;

   assign start_ok   = req && ready && io_ok && core_ok && !hold_off;
   assign stop_now   = !req || hold_off || !io_ok;
   assign io_release = (mode == MODE_TIMED) ? (cnt_q == UP_LAST) : above_ref;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      if (!ready || !core_ok) begin
         st_d  = SQ_IDLE;
         cnt_d = '0;
      end else begin
         unique case (st_q)
            SQ_IDLE: begin
               if (start_ok) begin
                  st_d  = SQ_CORE_UP;
                  cnt_d = '0;
               end
            end
            SQ_CORE_UP: begin
               if (stop_now) begin
                  st_d  = SQ_IO_DOWN;
                  cnt_d = '0;
               end else if (io_release) begin
                  st_d  = SQ_BOTH_UP;
                  cnt_d = '0;
               end else if (cnt_q != UP_LAST) begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            SQ_BOTH_UP: begin
               if (stop_now) begin
                  st_d  = SQ_IO_DOWN;
                  cnt_d = '0;
               end
            end
            SQ_IO_DOWN: begin
               if (cnt_q == DN_LAST) begin
                  st_d  = SQ_IDLE;
                  cnt_d = '0;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            default: begin
               st_d  = SQ_IDLE;
               cnt_d = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SQ_IDLE;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   // immediate-off conditions mask the registered state without waiting for an edge
   assign l_cmd = (st_q != SQ_IDLE) && ready && core_ok;
   assign m_cmd = (st_q == SQ_BOTH_UP) && ready && core_ok && io_ok && !hold_off;

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
   import pseq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int RST_CYCLES  = 1000,
   parameter int UP_DELAY    = 200,
   parameter int DOWN_DELAY  = 200
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       prim_ok,
   input  logic       io_ok,
   input  logic       core_ok,
   input  logic       gate_h_in,
   input  logic       seq_time_in,
   input  logic       seq_volt_in,
   input  logic       core_above_ref,
   input  logic [1:0] shut_code,
   output logic       ready,
   output logic       en_h,
   output logic       en_m,
   output logic       en_l,
   output logic [2:0] stat
);

   localparam int NSYNC = 3;

   logic [NSYNC-1:0] async_in, sync_out;
   logic      req;
   seq_mode_e mode;
   shut_req_t shut;
   logic      l_cmd, m_cmd, h_cmd;

   assign async_in = {core_above_ref, seq_volt_in, seq_time_in};
   assign shut     = decode_shut(shut_code);

   pseq_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (async_in),
      .dout  (sync_out)
   );

   pseq_ready_gen #(.RST_CYCLES(RST_CYCLES)) u_ready (
      .clk     (clk),
      .rst_n   (rst_n),
      .prim_ok (prim_ok),
      .ready   (ready)
   );

   pseq_req_latch u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .time_s   (sync_out[0]),
      .volt_s   (sync_out[1]),
      .req_nxt  (req),
      .mode_nxt (mode)
   );

   pseq_core_io_seq #(.UP_DELAY(UP_DELAY), .DOWN_DELAY(DOWN_DELAY)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .mode      (mode),
      .above_ref (sync_out[2]),
      .ready     (ready),
      .io_ok     (io_ok),
      .core_ok   (core_ok),
      .hold_off  (shut.drop_core_io),
      .l_cmd     (l_cmd),
      .m_cmd     (m_cmd)
   );

   assign h_cmd = gate_h_in && prim_ok && !shut.drop_primary;

   assign en_h = h_cmd;
   assign en_m = m_cmd;
   assign en_l = l_cmd;
   assign stat = {h_cmd, m_cmd, l_cmd};

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
   parameter int RST_CYCLES = 1000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       prim_ok,
   input logic       io_ok,
   input logic       core_ok,
   input logic       gate_h_in,
   input logic [1:0] shut_code,
   input logic       ready,
   input logic       en_h,
   input logic       en_m,
   input logic       en_l,
   input logic [2:0] stat
);

   p_ready_needs_prim_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !prim_ok |-> !ready);

   generate
      if (RST_CYCLES > 0) begin : g_rise
         p_ready_after_good_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ready) |-> $past(prim_ok));
      end
   endgenerate

   p_h_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
      en_h |-> (gate_h_in && prim_ok && !shut_code[1]));

   p_core_needs_rails_r3: assert property (@(posedge clk) disable iff (!rst_n)
      en_l |-> (ready && core_ok));

   p_io_needs_rail_r3: assert property (@(posedge clk) disable iff (!rst_n)
      en_m |-> io_ok);

   p_io_implies_core_r4: assert property (@(posedge clk) disable iff (!rst_n)
      en_m |-> en_l);

   p_status_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stat[1] |-> stat[0]);

   p_core_up_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_m) |-> $past(en_l));

   p_core_down_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(en_m) && ready && core_ok) |-> en_l);

   p_prim_fail_all_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !prim_ok |-> (!en_h && !en_m && !en_l));

   p_core_fail_both_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !core_ok |-> (!en_m && !en_l));

   p_shut_io_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
      shut_code[0] |-> !en_m);

endmodule

bind pwr_seq_ctrl pwr_seq_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (.*);

// File: tb/pwr_seq_ctrl_tb_top.sv
module pwr_seq_ctrl_tb_top;

   localparam int RST = 5;
   localparam int UP  = 4;
   localparam int DN  = 3;
   localparam logic [3:0] MR = 4'b1000;
   localparam logic [3:0] MH = 4'b0100;
   localparam logic [3:0] MM = 4'b0010;
   localparam logic [3:0] ML = 4'b0001;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic prim_ok = 1'b0, io_ok = 1'b0, core_ok = 1'b0, gate_h_in = 1'b0;
   logic seq_time_in = 1'b0, seq_volt_in = 1'b0, core_above_ref = 1'b0;
   logic [1:0] shut_code = 2'b00;
   logic ready, en_h, en_m, en_l;
   logic [2:0] stat;

   always #5 clk = ~clk;

   pwr_seq_ctrl #(.SYNC_STAGES(2), .RST_CYCLES(RST), .UP_DELAY(UP), .DOWN_DELAY(DN)) dut_i (
      .clk(clk), .rst_n(rst_n), .prim_ok(prim_ok), .io_ok(io_ok), .core_ok(core_ok),
      .gate_h_in(gate_h_in), .seq_time_in(seq_time_in), .seq_volt_in(seq_volt_in),
      .core_above_ref(core_above_ref), .shut_code(shut_code),
      .ready(ready), .en_h(en_h), .en_m(en_m), .en_l(en_l), .stat(stat)
   );

   typedef struct {
      int         due;
      logic [3:0] mask;
      logic [3:0] val;
      string      tag;
   } exp_t;

   exp_t q[$];
   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: pops expectations that fall due and compares them with the ports
   always @(negedge clk) begin
      logic [3:0] obs;
      obs = {ready, en_h, en_m, en_l};
      for (int i = q.size() - 1; i >= 0; i--) begin
         if (q[i].due == cyc) begin
            n_chk++;
            if ((obs & q[i].mask) !== (q[i].val & q[i].mask)) begin
               n_fail++;
               $display("FAIL %s: {ready,h,m,l}=%b expected %b under mask %b at cycle %0d",
                        q[i].tag, obs, q[i].val, q[i].mask, cyc);
            end
            n_chk++;
            if (stat !== {en_h, en_m, en_l}) begin
               n_fail++;
               $display("FAIL R14: stat=%b expected %b", stat, {en_h, en_m, en_l});
            end
            n_chk++;
            if (en_m && !en_l) begin
               n_fail++;
               $display("FAIL R4: en_m=%b en_l=%b expected en_m=0 with en_l=0", en_m, en_l);
            end
            q.delete(i);
         end else if (q[i].due < cyc) begin
            n_chk++;
            n_fail++;
            $display("FAIL %s: expectation missed, actual cycle %0d expected cycle %0d",
                     q[i].tag, cyc, q[i].due);
            q.delete(i);
         end
      end
   end

   task automatic push_exp(input int dly, input logic [3:0] mask, input logic [3:0] val,
                           input string tag);
      exp_t e;
      e.due = cyc + dly; e.mask = mask; e.val = val; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic drain();
      while (q.size() != 0) @(negedge clk);
      tick(1);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      #1;
      push_exp(0, 4'hF, 4'h0, "R1 reset state");
      drain();

      // R1 / R2: primary rail comes up, I/O rail still bad
      core_ok = 1'b1; gate_h_in = 1'b1;
      tick(1);
      prim_ok = 1'b1;
      push_exp(0, MH, MH, "R2 primary enable");
      push_exp(0, MR, 4'h0, "R1 ready waits");
      push_exp(RST - 1, MR, 4'h0, "R1 ready waits");
      push_exp(RST, MR, MR, "R1 ready after interval");
      drain();

      // R3: request with a bad I/O rail starts nothing
      seq_time_in = 1'b1;
      push_exp(3, ML, 4'h0, "R3 core held off");
      push_exp(6, ML | MM, 4'h0, "R3 core held off");
      drain();
      seq_time_in = 1'b0;
      tick(5);
      io_ok = 1'b1;
      push_exp(2, ML, 4'h0, "R3 withdrawn request stays off");
      drain();

      // R5: timed start
      seq_time_in = 1'b1;
      push_exp(2, ML, 4'h0, "R5 core before sync");
      push_exp(3, ML, ML, "R5 core on");
      push_exp(3 + UP - 1, MM, 4'h0, "R5 io waits");
      push_exp(3 + UP, MM, MM, "R5 io on");
      drain();

      // R10: I/O rail failure and recovery
      io_ok = 1'b0;
      push_exp(0, MM, 4'h0, "R10 io off at once");
      push_exp(DN, ML, ML, "R10 core held");
      push_exp(DN + 1, ML, 4'h0, "R10 core off");
      drain();
      io_ok = 1'b1;
      push_exp(1, ML, ML, "R5 restart core");
      push_exp(1 + UP, MM, MM, "R5 restart io");
      drain();

      // R11: core rail failure
      core_ok = 1'b0;
      push_exp(0, ML | MM, 4'h0, "R11 both off");
      push_exp(2, ML | MM, 4'h0, "R11 both stay off");
      drain();
      core_ok = 1'b1;
      push_exp(1, ML, ML, "R5 restart core");
      push_exp(1 + UP, MM, MM, "R5 restart io");
      drain();

      // R12 code 01, then R13 clear
      shut_code = 2'b01;
      push_exp(0, MM, 4'h0, "R12 code 01 io off");
      push_exp(0, MH | ML, MH | ML, "R12 code 01 keeps h and core");
      push_exp(DN, ML, ML, "R12 code 01 core held");
      push_exp(DN + 1, ML, 4'h0, "R12 code 01 core off");
      drain();
      shut_code = 2'b00;
      push_exp(1, ML, ML, "R13 core back");
      push_exp(UP, MM, 4'h0, "R13 io waits");
      push_exp(1 + UP, MM, MM, "R13 io back");
      drain();

      // R12 code 10
      shut_code = 2'b10;
      push_exp(0, MH, 4'h0, "R12 code 10 h off");
      push_exp(0, MM | ML, MM | ML, "R12 code 10 pair kept");
      push_exp(DN + 2, MM | ML, MM | ML, "R12 code 10 pair kept");
      drain();
      shut_code = 2'b00;
      push_exp(0, MH, MH, "R13 h back");
      drain();

      // R12 code 11, then R13 clear
      shut_code = 2'b11;
      push_exp(0, MH | MM, 4'h0, "R12 code 11 h and io off");
      push_exp(DN, ML, ML, "R12 code 11 core held");
      push_exp(DN + 1, ML, 4'h0, "R12 code 11 core off");
      drain();
      shut_code = 2'b00;
      push_exp(0, MH | ML, MH, "R13 h first, core next edge");
      push_exp(1, ML, ML, "R13 core back");
      push_exp(1 + UP, MM, MM, "R13 io back");
      drain();

      // R6: timed stop
      seq_time_in = 1'b0;
      push_exp(2, MM, MM, "R6 io before sync");
      push_exp(3, MM, 4'h0, "R6 io off");
      push_exp(3 + DN - 1, ML, ML, "R6 core held");
      push_exp(3 + DN, ML, 4'h0, "R6 core off");
      drain();

      // R7: threshold style
      seq_volt_in = 1'b1;
      push_exp(3, ML | MM, ML, "R7 core on, io off");
      push_exp(8, MM, 4'h0, "R7 io waits for comparator");
      drain();
      core_above_ref = 1'b1;
      push_exp(2, MM, 4'h0, "R7 io before sync");
      push_exp(3, MM, MM, "R7 io on");
      drain();
      seq_volt_in = 1'b0;
      push_exp(3, MM, 4'h0, "R7 io off");
      push_exp(3 + DN - 1, ML, ML, "R7 core held");
      push_exp(3 + DN, ML, 4'h0, "R7 core off");
      drain();

      // R8: falling edge of the non-selected pin
      seq_volt_in = 1'b1;
      push_exp(3, ML, ML, "R7 core on");
      push_exp(4, MM, MM, "R7 io on with comparator high");
      drain();
      seq_time_in = 1'b1;
      tick(4);
      seq_volt_in = 1'b0;
      push_exp(5, MM | ML, MM | ML, "R8 ignored falling edge");
      drain();
      seq_time_in = 1'b0;
      push_exp(3, MM, 4'h0, "R6 io off");
      push_exp(3 + DN, ML, 4'h0, "R6 core off");
      drain();

      // R9: primary failure with everything on
      seq_time_in = 1'b1;
      push_exp(3 + UP, MM | ML | MH | MR, 4'hF, "R5 all on");
      drain();
      prim_ok = 1'b0;
      push_exp(0, 4'hF, 4'h0, "R9 all off at once");
      drain();

      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual run still busy, expected completion");
         summary();
         $finish;
      end
   end

endmodule